// File: doc/BRIEF.md
# Network Adapter Host Glue Register Window

This block sits between a host I/O bus and a network controller on an adapter card. The host sees a 16-byte window. The upper eight offsets hold the glue control registers. The lower eight offsets show one of two things, chosen by a control bit:

- the controller's interface registers, or
- an identification ROM with two pages. One page carries the maker and adapter identity plus copies of the configuration bytes. The other page carries the six-byte station address.

The controller has more registers than the host address lines can reach. A page bit in the glue therefore supplies the top bit of the controller's register index.

The glue also drives four outputs:

- the controller reset line,
- a line-speed select pin,
- a cable-type select pin,
- a level-sensitive host interrupt, which can be shared with other devices.

The interrupt comes from a pending latch. The latch is set by a controller interrupt request while forwarding is enabled. The host acknowledges it by clearing the forwarding enable and setting it again. In this model the controller is a plain 16-entry byte register file. Bus read data is combinational from the address.

Top module: `adapter_glue`

## Requirements
- R1: After reset every control bit and the pending latch are zero. At reset the window shows ROM page zero, `ctl_rst_n`, `host_irq`, `speed_16` and `cable_utp` are low, and control registers 0 and 1 read 0x00.
- R2: With control register 0 (offset 8) bit 2 clear and bit 3 clear, the data offsets read ROM page zero, as follows:
  - offset 0: manufacturer ID
  - offset 1: adapter type
  - offset 2: revision
  - offsets 3, 4, 5: the inputs `cfg0`, `cfg1`, `cfg2`
  - offsets 6 and 7: 0x00
- R3: With control register 0 bit 2 clear and bit 3 set, the data offsets read ROM page one, as follows:
  - offset 0: 0x00
  - offsets 1 to 6: the 48-bit station address, most significant byte at offset 1
  - offset 7: 0x00
- R4: With control register 0 bit 2 set, the data offsets read and write controller registers. While that bit is clear, writes to data offsets are ignored and leave the controller registers unchanged.
- R5: A data offset o reaches controller register index {control register 1 bit 3, o[2:0]}. Controller registers 8 to 15 are therefore reached at offset minus 8 while that bit is set.
- R6: Control register 1 (offset 9) bit 0 drives `ctl_rst_n`. While it is low, the controller registers are held at zero and writes to them are ignored.
- R7: While control register 1 bit 1 (forwarding enable) is set, a high `ctl_irq` sets the pending latch one cycle later. `host_irq` and control register 0 bit 7 (read-only) both show the latch, and it holds after `ctl_irq` falls.
- R8: Clearing the forwarding enable clears the latch. While the enable is clear, `ctl_irq` is ignored. Setting the enable again does not raise the latch until a new `ctl_irq` arrives.
- R9: Control register 1 bit 2 drives `speed_16`: high selects 16 Mb/s and low selects 4 Mb/s.
- R10: Control register 7 (offset 15) bit 0 drives `cable_utp`: high selects unshielded cable and low selects shielded cable.
- R11: Control register 0 reads as follows:
  - bit 7: latch
  - bit 3: ROM page
  - bit 2: controller map
  - all other bits: 0

  Control register 1 reads its bits 3 to 0, with the upper bits 0. Control registers 2 to 6 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Window offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cfg0 | input | 8 | Configuration byte 0, mirrored in the ROM |
| cfg1 | input | 8 | Configuration byte 1, mirrored in the ROM |
| cfg2 | input | 8 | Configuration byte 2, mirrored in the ROM |
| ctl_irq | input | 1 | Interrupt request from the controller |
| ctl_rst_n | output | 1 | Controller reset, active low |
| host_irq | output | 1 | Level host interrupt |
| speed_16 | output | 1 | Line speed select |
| cable_utp | output | 1 | Cable type select |

## Verification
The bench builds the block with the following parameters:
- adapter type 0x0D
- revision 0x05
- station address A1B2C3D4E5F6

It also drives distinct configuration bytes, so every ROM byte in both pages has a value unlike its neighbours, and a swapped or shifted byte shows up. All 16 controller registers are written through both settings of the page bit, each with a distinct arithmetic pattern, which exposes any aliasing in the index. The interrupt sequence covers four cases: a request while disabled, a set, a hold, and re-arming with and without a new request.

// File: rtl/adapter_glue.sv
module adapter_glue #(
  parameter logic [7:0]  MFR_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  CARD_REV  = 8'h01,
  parameter logic [47:0] STN_ADDR  = 48'h0000F6000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] cfg0,
  input  logic [7:0] cfg1,
  input  logic [7:0] cfg2,
  input  logic       ctl_irq,
  output logic       ctl_rst_n,
  output logic       host_irq,
  output logic       speed_16,
  output logic       cable_utp
);
  localparam int NREG = 16;

  logic       map_ctl, rom_pg, pend;
  logic [3:0] c1;
  logic       cab;
  logic [7:0] ctl_q [NREG];
  logic [7:0] rom_b;

  wire        in_ctl  = bus_addr[3];
  wire        wr_ctl  = bus_we && in_ctl;
  wire        wr_c0   = wr_ctl && bus_addr[2:0] == 3'd0;
  wire        wr_c1   = wr_ctl && bus_addr[2:0] == 3'd1;
  wire        wr_c7   = wr_ctl && bus_addr[2:0] == 3'd7;
  wire [3:0]  ctl_idx = {c1[3], bus_addr[2:0]};
  wire        en_nxt  = wr_c1 ? bus_wdata[1] : c1[1];

  assign ctl_rst_n = c1[0];
  assign speed_16  = c1[2];
  assign cable_utp = cab;
  assign host_irq  = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_ctl <= 1'b0;
      rom_pg  <= 1'b0;
      c1      <= 4'h0;
      cab     <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_c0) begin
        map_ctl <= bus_wdata[2];
        rom_pg  <= bus_wdata[3];
      end
      if (wr_c1) c1 <= bus_wdata[3:0];
      if (wr_c7) cab <= bus_wdata[0];
      pend <= en_nxt && (pend || (ctl_irq && c1[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ctl_q[i] <= 8'h00;
    end else if (!c1[0]) begin
      for (int i = 0; i < NREG; i++) ctl_q[i] <= 8'h00;
    end else if (bus_we && !in_ctl && map_ctl) begin
      ctl_q[ctl_idx] <= bus_wdata;
    end
  end

  always_comb begin
    rom_b = 8'h00;
    if (!rom_pg) begin
      case (bus_addr[2:0])
        3'd0: rom_b = MFR_ID;
        3'd1: rom_b = CARD_TYPE;
        3'd2: rom_b = CARD_REV;
        3'd3: rom_b = cfg0;
        3'd4: rom_b = cfg1;
        3'd5: rom_b = cfg2;
        default: rom_b = 8'h00;
      endcase
    end else if (bus_addr[2:0] != 3'd0 && bus_addr[2:0] != 3'd7) begin
      rom_b = STN_ADDR[8*(6 - int'(bus_addr[2:0])) +: 8];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (!in_ctl) bus_rdata = map_ctl ? ctl_q[ctl_idx] : rom_b;
    else case (bus_addr[2:0])
      3'd0: bus_rdata = {pend, 3'b000, rom_pg, map_ctl, 2'b00};
      3'd1: bus_rdata = {4'h0, c1};
      3'd7: bus_rdata = {7'h00, cab};
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> c1[1]);
  assert_irq_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_irq && c1[1] && !wr_c1) |=> host_irq);
  assert_en_fall_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c1[1]) |-> !host_irq);
  assert_speed_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c1 |=> speed_16 == $past(bus_wdata[2]));
  assert_cable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c7 |=> cable_utp == $past(bus_wdata[0]));
  assert_ctl_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rst_n && map_ctl && !wr_c0 && !wr_c1 && !in_ctl) |=> (in_ctl || bus_rdata == 8'h00 || !map_ctl));
endmodule

// File: tb/adapter_glue_bench.sv
module adapter_glue_bench;
  localparam logic [7:0]  TYP = 8'h0D;
  localparam logic [7:0]  REV = 8'h05;
  localparam logic [47:0] STA = 48'hA1B2C3D4E5F6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [7:0] cfg0 = 8'h5A, cfg1 = 8'h3C, cfg2 = 8'hC3;
  logic ctl_irq = 1'b0;
  logic ctl_rst_n, host_irq, speed_16, cable_utp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adapter_glue #(.CARD_TYPE(TYP), .CARD_REV(REV), .STN_ADDR(STA)) u_adapter_glue (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg0(cfg0), .cfg1(cfg1),
    .cfg2(cfg2), .ctl_irq(ctl_irq), .ctl_rst_n(ctl_rst_n), .host_irq(host_irq),
    .speed_16(speed_16), .cable_utp(cable_utp));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_irq();
    @(negedge clk); ctl_irq = 1'b1;
    @(negedge clk); ctl_irq = 1'b0;
  endtask

  function automatic logic [7:0] rom_exp(input int pg, input int k);
    if (pg == 0) begin
      case (k)
        0: return 8'h4D;
        1: return TYP;
        2: return REV;
        3: return cfg0;
        4: return cfg1;
        5: return cfg2;
        default: return 8'h00;
      endcase
    end
    if (k >= 1 && k <= 6) return 8'((STA >> (8 * (6 - k))) & 48'hFF);
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rst_n", {7'd0, ctl_rst_n}, 8'h00);
    chk("R1 irq", {7'd0, host_irq}, 8'h00);
    chk("R1 speed", {7'd0, speed_16}, 8'h00);
    chk("R1 cable", {7'd0, cable_utp}, 8'h00);
    rd(4'd8, d); chk("R1 ctrl0", d, 8'h00);
    rd(4'd9, d); chk("R1 ctrl1", d, 8'h00);
    // R2 page zero
    for (int k = 0; k < 8; k++) begin rd(4'(k), d); chk("R2 page0", d, rom_exp(0, k)); end
    // R3 page one
    wr(4'd8, 8'h08);
    for (int k = 0; k < 8; k++) begin rd(4'(k), d); chk("R3 page1", d, rom_exp(1, k)); end
    // R11 control read map
    rd(4'd8, d); chk("R11 ctrl0", d, 8'h08);
    for (int k = 10; k < 15; k++) begin rd(4'(k), d); chk("R11 ctrl2-6 zero", d, 8'h00); end
    // R6 writes ignored while controller reset
    wr(4'd8, 8'h04);
    wr(4'd2, 8'h77);
    rd(4'd2, d); chk("R6 held", d, 8'h00);
    wr(4'd9, 8'h01);
    chk("R6 released", {7'd0, ctl_rst_n}, 8'h01);
    // R5 indexed sweep through page bit
    for (int s = 0; s < 2; s++) begin
      wr(4'd9, 8'(8'h01 | (s << 3)));
      for (int o = 0; o < 8; o++) wr(4'(o), pat(s * 8 + o));
    end
    for (int s = 0; s < 2; s++) begin
      wr(4'd9, 8'(8'h01 | (s << 3)));
      rd(4'd9, d); chk("R11 ctrl1", d, 8'(8'h01 | (s << 3)));
      for (int o = 0; o < 8; o++) begin rd(4'(o), d); chk("R5 index", d, pat(s * 8 + o)); end
    end
    // R4 writes ignored while ROM mapped
    wr(4'd8, 8'h00);
    wr(4'd9, 8'h01);
    for (int o = 0; o < 8; o++) wr(4'(o), 8'hEE);
    for (int o = 0; o < 8; o++) begin rd(4'(o), d); chk("R4 rom view", d, rom_exp(0, o)); end
    wr(4'd8, 8'h04);
    for (int o = 0; o < 8; o++) begin rd(4'(o), d); chk("R4 untouched", d, pat(o)); end
    // R6 controller reset clears
    wr(4'd9, 8'h00);
    wr(4'd9, 8'h01);
    for (int o = 0; o < 8; o++) begin rd(4'(o), d); chk("R6 cleared", d, 8'h00); end
    // R8 request ignored while disabled
    pulse_irq();
    @(negedge clk);
    chk("R8 disabled", {7'd0, host_irq}, 8'h00);
    // R7 set and hold
    wr(4'd9, 8'h03);
    chk("R8 enable no raise", {7'd0, host_irq}, 8'h00);
    pulse_irq();
    chk("R7 set", {7'd0, host_irq}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R7 hold", {7'd0, host_irq}, 8'h01);
    rd(4'd8, d); chk("R7 sintr", d, 8'h84);
    // R8 toggle clears, re-arm needs new request
    wr(4'd9, 8'h01);
    chk("R8 cleared", {7'd0, host_irq}, 8'h00);
    wr(4'd9, 8'h03);
    repeat (2) @(negedge clk);
    chk("R8 rearm quiet", {7'd0, host_irq}, 8'h00);
    rd(4'd8, d); chk("R8 sintr clear", d, 8'h04);
    pulse_irq();
    chk("R8 new request", {7'd0, host_irq}, 8'h01);
    // R9 speed
    wr(4'd9, 8'h07); chk("R9 16", {7'd0, speed_16}, 8'h01);
    wr(4'd9, 8'h03); chk("R9 4", {7'd0, speed_16}, 8'h00);
    // R10 cable
    wr(4'd15, 8'h01); chk("R10 utp", {7'd0, cable_utp}, 8'h01);
    rd(4'd15, d); chk("R10 read", d, 8'h01);
    wr(4'd15, 8'hFE); chk("R10 stp", {7'd0, cable_utp}, 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 00 expected 01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule